// File: doc/BRIEF.md
# Daisy-Chained Serial Register Slave

This block gives one device on a serial daisy chain its control-register port. A shared serial clock and a command line reach every device in parallel. Each device has two serial pins: an upstream pin facing the controller and a downstream pin facing the next device. Each pin is split into an input, an output and an output enable. The block runs on a fast core clock and oversamples the serial clock. When it sees the start pattern on the command line, it takes in a 64-bit request made of a request word, an address word and two more words. It then writes or reads a small bank of 16-bit registers.

Request bits are repeated from the upstream pin to the downstream pin with no added delay, so every device sees the same bits on the same edge. A read runs the other way. In its fourth packet the addressed device turns its pins around and drives the response toward the controller. Every device between it and the controller hands that response upstream from its downstream pin. When a request is broadcast, the read response comes from a single device chosen by parameter, so that no two devices drive the line at once.

Top module: `srs_chain_slave`

## Requirements
- R1: A transaction starts only after the eight most recent command-line samples, taken on both edges of the serial clock with the oldest first, equal 11110000. Any other pattern starts nothing, and the data that follows changes no register.
- R2: Slot 0 is the first falling edge after the start pattern. Slots 0-15 carry the request, slots 16-31 the address and slots 32-47 the data, each most significant bit first. Request bits 15:12 are the opcode, where 1 means write and 2 means read. Bit 11 is the broadcast flag, and bits 5:0 are the device number. The register address is in bits 11:0 of the address word. A write to this device stores the data word at that address.
- R3: On a read addressed to this device, the upstream enable is high from slot 48 through slot 65. The upstream output carries 0 in slot 48, register bits 15 down to 0 in slots 49-64, and 0 in slot 65. The enable is low in the first slot after the read.
- R4: A write whose device number differs from this device's number, with the broadcast flag clear, leaves this device's registers unchanged.
- R5: A broadcast write stores into every device. A broadcast read is answered only by the device whose number equals the broadcast-responder parameter.
- R6: Addresses at or above the register count read back as zero and ignore writes. The highest implemented address holds data.
- R7: Outside a read response window, the downstream enable is high and the downstream output equals the upstream input. This holds when idle, in all slots of a write, and in slots 0-47 of a read.
- R8: In slots 48-65 of a read that this device does not answer, the downstream enable is low. The upstream enable is high and the upstream output equals the downstream input. In slots 48-65 of a read that this device answers, the downstream enable is also low.
- R9: After reset, every register reads zero, the upstream enable is low and the downstream enable is high.
- R10: A request whose opcode is neither 1 nor 2 stores nothing and produces no response window.
- R11: A start pattern on the command line during a transaction is ignored. The running transaction completes as sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Shared serial clock, idle high |
| cmd | input | 1 | Shared command line carrying the start pattern |
| sio_up_i | input | 1 | Upstream pin, input side |
| sio_up_o | output | 1 | Upstream pin, output side (read response) |
| sio_up_oe | output | 1 | Upstream pin drive enable |
| sio_dn_i | input | 1 | Downstream pin, input side (response from the next device) |
| sio_dn_o | output | 1 | Downstream pin, output side (repeated request bits) |
| sio_dn_oe | output | 1 | Downstream pin drive enable |

## Verification
Pin turnaround is the point where two functions meet. The falling edge that closes slot 47 must end the request repeat and, on the same core-clock update, start either this device's own response or the relay of the next device's response. The bench links two instances in a chain and reads from the near device, the far device and by broadcast. In every slot it samples the enables and the bit that reaches the far device. A response word that is present but shifted, a slot of overlap, or a response from both devices on a broadcast read shows up as a wrong word or a wrong count of enabled slots. An assertion ties every change of the upstream enable to a serial falling edge.

// File: rtl/srs_pkg.sv
`timescale 1ns/1ps
package srs_pkg;
   localparam int OP_W  = 4;
   localparam int DEV_W = 6;
   localparam logic [OP_W-1:0] OP_WRITE = 4'h1;
   localparam logic [OP_W-1:0] OP_READ  = 4'h2;
   typedef enum logic {ST_IDLE, ST_BUSY} eng_st_e;
endpackage

// File: rtl/srs_sync.sv
`timescale 1ns/1ps
module srs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   input  logic [W-1:0] rst_val,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= rst_val;
               else if (i == 0) stg[i] <= d;
               else stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/srs_frame.sv
`timescale 1ns/1ps
module srs_frame #(
   parameter int                PAT_W = 8,
   parameter logic [PAT_W-1:0]  PAT   = 8'hF0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   input  logic cmd_s,
   input  logic arm,
   input  logic clr,
   output logic hit
);
   logic [PAT_W-2:0] hist;
   logic [PAT_W-1:0] nxt;

   generate
      if (PAT_W < 2) begin : g_bad_w
         $error("srs_frame: pattern must be at least two samples");
      end
   endgenerate

   assign nxt = {hist, cmd_s};
   assign hit = arm && smp && (nxt == PAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hist <= '0;
      else if (clr || hit) hist <= '0;
      else if (smp)        hist <= nxt[PAT_W-2:0];
   end
endmodule

// File: rtl/srs_regs.sv
`timescale 1ns/1ps
module srs_regs #(
   parameter int NUM_REGS = 8,
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rdata
);
   localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   generate
      if (NUM_REGS < 2 || IW > ADDR_W) begin : g_bad_n
         $error("srs_regs: register count out of range for address width");
      end
   endgenerate

   logic [DATA_W-1:0] bank [NUM_REGS];
   logic              in_range;

   assign in_range = ({{(32-ADDR_W){1'b0}}, addr} < NUM_REGS);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank[i] <= '0;
            else if (wr_en && in_range && addr[IW-1:0] == IW'(i)) bank[i] <= wr_data;
         end
      end
   endgenerate

   assign rdata = in_range ? bank[addr[IW-1:0]] : '0;

   AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R2
endmodule

// File: rtl/srs_engine.sv
`timescale 1ns/1ps
module srs_engine import srs_pkg::*; #(
   parameter int PKT_W         = 16,
   parameter int ADDR_W        = 12,
   parameter int DEV_ID        = 0,
   parameter int BCAST_RESP_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall,
   input  logic              frame_hit,
   input  logic              bit_in,
   input  logic [PKT_W-1:0]  rdata,
   output logic              busy,
   output logic              done,
   output logic              wr_en,
   output logic [ADDR_W-1:0] addr,
   output logic [PKT_W-1:0]  wr_data,
   output logic              win_own,
   output logic              win_fwd,
   output logic              resp_bit
);
   localparam int TXN_SLOTS  = 4 * PKT_W;
   localparam int RESP_START = 3 * PKT_W;
   localparam int RESP_END   = RESP_START + PKT_W + 1;
   localparam int CNT_W      = $clog2(RESP_END + 2);
   localparam logic [CNT_W-1:0] K_REQ  = CNT_W'(PKT_W - 1);
   localparam logic [CNT_W-1:0] K_ADR  = CNT_W'(2 * PKT_W - 1);
   localparam logic [CNT_W-1:0] K_DAT  = CNT_W'(3 * PKT_W - 1);
   localparam logic [CNT_W-1:0] K_WEND = CNT_W'(TXN_SLOTS - 1);
   localparam logic [CNT_W-1:0] K_RS   = CNT_W'(RESP_START);
   localparam logic [CNT_W-1:0] K_RE   = CNT_W'(RESP_END);

   generate
      if (PKT_W < OP_W + 1 + DEV_W) begin : g_bad_pkt
         $error("srs_engine: packet too narrow for request fields");
      end
      if (ADDR_W > PKT_W) begin : g_bad_addr
         $error("srs_engine: address wider than packet");
      end
      if (DEV_ID >= (1 << DEV_W) || BCAST_RESP_ID >= (1 << DEV_W)) begin : g_bad_id
         $error("srs_engine: device number out of range");
      end
   endgenerate

   eng_st_e          st;
   logic [CNT_W-1:0] cnt;
   logic [PKT_W-2:0] sh;
   logic [PKT_W-1:0] shin;
   logic [PKT_W-1:0] rd_q;
   logic [OP_W-1:0]  op_q;
   logic             bc_q;
   logic [DEV_W-1:0] dev_q;
   logic             is_rd, is_wr, sel_wr, responder, last_slot, win, mid;

   assign shin      = {sh, bit_in};
   assign is_rd     = (op_q == OP_READ);
   assign is_wr     = (op_q == OP_WRITE);
   assign sel_wr    = bc_q || (dev_q == DEV_W'(DEV_ID));
   assign responder = bc_q ? (DEV_ID == BCAST_RESP_ID) : (dev_q == DEV_W'(DEV_ID));
   assign last_slot = is_rd ? (cnt == K_RE) : (cnt == K_WEND);
   assign busy      = (st == ST_BUSY);
   assign win       = busy && is_rd && cnt >= K_RS && cnt <= K_RE;
   assign mid       = cnt > K_RS && cnt < K_RE;
   assign win_own   = win && responder;
   assign win_fwd   = win && !responder;
   assign resp_bit  = win_own && mid && rd_q[PKT_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         sh      <= '0;
         rd_q    <= '0;
         op_q    <= '0;
         bc_q    <= 1'b0;
         dev_q   <= '0;
         addr    <= '0;
         wr_data <= '0;
         wr_en   <= 1'b0;
         done    <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         done  <= 1'b0;
         if (st == ST_IDLE) begin
            if (frame_hit) begin
               st    <= ST_BUSY;
               cnt   <= '0;
               op_q  <= '0;
               bc_q  <= 1'b0;
               dev_q <= '0;
            end
         end else if (fall) begin
            sh  <= shin[PKT_W-2:0];
            cnt <= cnt + CNT_W'(1);
            if (cnt == K_REQ) begin
               op_q  <= shin[PKT_W-1 -: OP_W];
               bc_q  <= shin[PKT_W-1-OP_W];
               dev_q <= shin[DEV_W-1:0];
            end
            if (cnt == K_ADR) addr <= shin[ADDR_W-1:0];
            if (cnt == K_DAT) begin
               rd_q <= rdata;
               if (is_wr && sel_wr) begin
                  wr_en   <= 1'b1;
                  wr_data <= shin;
               end
            end
            if (mid) rd_q <= {rd_q[PKT_W-2:0], 1'b0};
            if (last_slot) begin
               st   <= ST_IDLE;
               done <= 1'b1;
            end
         end
      end
   end

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fall && !last_slot) |=> (busy && cnt == $past(cnt) + CNT_W'(1))); // R11

   AST_WR_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy); // R4
endmodule

// File: rtl/srs_chain_slave.sv
`timescale 1ns/1ps
module srs_chain_slave #(
   parameter int         PKT_W         = 16,
   parameter int         ADDR_W        = 12,
   parameter int         NUM_REGS      = 8,
   parameter int         DEV_ID        = 0,
   parameter int         BCAST_RESP_ID = 0,
   parameter int         SYNC_STAGES   = 2,
   parameter logic [7:0] FRAME_PAT     = 8'hF0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cmd,
   input  logic sio_up_i,
   output logic sio_up_o,
   output logic sio_up_oe,
   input  logic sio_dn_i,
   output logic sio_dn_o,
   output logic sio_dn_oe
);
   logic              sck_s, cmd_s, up_s, sck_q, sck_fall, sck_rise;
   logic              frame_hit, busy, done, wr_en, win_own, win_fwd, resp_bit;
   logic [ADDR_W-1:0] addr;
   logic [PKT_W-1:0]  wr_data, rdata;

   srs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sck, cmd, sio_up_i}), .rst_val(3'b100),
      .q({sck_s, cmd_s, up_s}));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b1;
      else        sck_q <= sck_s;
   end
   assign sck_fall = sck_q && !sck_s;
   assign sck_rise = !sck_q && sck_s;

   srs_frame #(.PAT_W(8), .PAT(FRAME_PAT)) u_frame (
      .clk(clk), .rst_n(rst_n), .smp(sck_fall || sck_rise), .cmd_s(cmd_s),
      .arm(!busy), .clr(done), .hit(frame_hit));

   srs_engine #(.PKT_W(PKT_W), .ADDR_W(ADDR_W), .DEV_ID(DEV_ID),
                .BCAST_RESP_ID(BCAST_RESP_ID)) u_eng (
      .clk(clk), .rst_n(rst_n), .fall(sck_fall), .frame_hit(frame_hit),
      .bit_in(up_s), .rdata(rdata), .busy(busy), .done(done), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .win_own(win_own), .win_fwd(win_fwd),
      .resp_bit(resp_bit));

   srs_regs #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(PKT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rdata(rdata));

   assign sio_dn_o  = sio_up_i;
   assign sio_dn_oe = !(win_own || win_fwd);
   assign sio_up_oe = win_own || win_fwd;
   assign sio_up_o  = win_fwd ? sio_dn_i : resp_bit;

   AST_TURN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (sio_up_oe != $past(sio_up_oe)) |-> $past(sck_fall)); // R3

   AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sio_up_oe) && !win_fwd) |-> !sio_up_o); // R3

   AST_IDLE_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sio_dn_oe); // R7
endmodule

// File: tb/tb_srs_chain_slave.sv
`timescale 1ns/1ps
module tb_srs_chain_slave;
   localparam logic [3:0] OPW = 4'h1;
   localparam logic [3:0] OPR = 4'h2;
   localparam logic [7:0] GOODF = 8'hF0;
   localparam logic [7:0] BADF  = 8'hE0;

   logic clk = 1'b0, rst_n = 1'b0, sck = 1'b1, cmd = 1'b0, ctl_din = 1'b0;
   always #10 clk = ~clk;

   logic dut_up_o, dut_up_oe, dut_dn_o, dut_dn_oe, dut_dn_i;
   logic d1_up_i, d1_up_o, d1_up_oe, d1_dn_o, d1_dn_oe;

   assign d1_up_i  = dut_dn_oe ? dut_dn_o : 1'b0;
   assign dut_dn_i = d1_up_oe ? d1_up_o : 1'b0;

   srs_chain_slave #(.DEV_ID(3), .BCAST_RESP_ID(5)) dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cmd(cmd), .sio_up_i(ctl_din),
      .sio_up_o(dut_up_o), .sio_up_oe(dut_up_oe), .sio_dn_i(dut_dn_i),
      .sio_dn_o(dut_dn_o), .sio_dn_oe(dut_dn_oe));

   srs_chain_slave #(.DEV_ID(5), .BCAST_RESP_ID(5)) dev1 (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cmd(cmd), .sio_up_i(d1_up_i),
      .sio_up_o(d1_up_o), .sio_up_oe(d1_up_oe), .sio_dn_i(1'b0),
      .sio_dn_o(d1_dn_o), .sio_dn_oe(d1_dn_oe));

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   logic o_up, o_upoe, o_dnoe, o_link;
   logic [17:0] r_resp;
   int r_winoe, r_stray, r_fwd, r_dnrel;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic slot(input logic d, input logic cf, input logic cr);
      @(negedge clk);
      ctl_din = d;
      cmd     = cf;
      repeat (4) @(negedge clk);
      o_up = dut_up_o; o_upoe = dut_up_oe; o_dnoe = dut_dn_oe; o_link = d1_up_i;
      sck = 1'b0;
      repeat (4) @(negedge clk);
      cmd = cr;
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic txn(input logic good, input int inj, input logic [3:0] op, input logic bc,
                      input logic [5:0] dev, input logic [11:0] a, input logic [15:0] data);
      logic [63:0] pk;
      logic [7:0]  fp;
      bit          rd;
      rd = (op == OPR);
      pk = {op, bc, 5'b0, dev, 4'b0, a, (rd ? 16'h0 : data), 16'h0};
      fp = good ? GOODF : BADF;
      r_resp = '0; r_winoe = 0; r_stray = 0; r_fwd = 0; r_dnrel = 0;
      for (int i = 0; i < 4; i++) slot(1'b0, fp[7-2*i], fp[6-2*i]);
      for (int s = 0; s < 67; s++) begin
         logic d, cf, cr;
         d  = (s < 64) ? pk[63-s] : 1'b0;
         cf = 1'b0;
         cr = 1'b0;
         if (inj >= 0 && s >= inj && s < inj + 4) begin
            cf = GOODF[7-2*(s-inj)];
            cr = GOODF[6-2*(s-inj)];
         end
         slot(d, cf, cr);
         if (rd && s >= 48 && s <= 65) begin
            r_resp[65-s] = o_up;
            if (o_upoe) r_winoe++;
            if (!o_dnoe) r_dnrel++;
         end else begin
            if (o_upoe) r_stray++;
            if (!o_dnoe || o_link !== d) r_fwd++;
         end
      end
   endtask

   task automatic rd_chk(input string tag, input logic bc, input logic [5:0] dev,
                         input logic [11:0] a, input logic [15:0] exp);
      txn(1'b1, -1, OPR, bc, dev, a, 16'h0);
      chk({tag, " word"}, 32'(r_resp), 32'({1'b0, exp, 1'b0}));
      chk({tag, " enabled slots"}, r_winoe, 18);
      chk({tag, " dn released"}, r_dnrel, 18);
      chk({tag, " stray/forward"}, r_stray + r_fwd, 0);
   endtask

   task automatic t_reset;
      chk("R9 up_oe after reset", 32'(dut_up_oe), 0);
      chk("R9 dn_oe after reset", 32'(dut_dn_oe), 1);
      rd_chk("R9 reg0 reset", 1'b0, 6'd3, 12'h000, 16'h0000);
   endtask

   task automatic t_own_write;
      txn(1'b1, -1, OPW, 1'b0, 6'd3, 12'h002, 16'hA5C3);
      chk("R7 repeat during write", r_fwd, 0);
      chk("R7 no upstream drive on write", r_stray, 0);
      rd_chk("R2 R3 readback own", 1'b0, 6'd3, 12'h002, 16'hA5C3);
   endtask

   task automatic t_other_device;
      txn(1'b1, -1, OPW, 1'b0, 6'd5, 12'h002, 16'h1234);
      rd_chk("R4 other-device write ignored", 1'b0, 6'd3, 12'h002, 16'hA5C3);
      rd_chk("R8 relay far response", 1'b0, 6'd5, 12'h002, 16'h1234);
   endtask

   task automatic t_broadcast;
      txn(1'b1, -1, OPW, 1'b1, 6'd0, 12'h004, 16'hBEEF);
      rd_chk("R5 bcast write near", 1'b0, 6'd3, 12'h004, 16'hBEEF);
      rd_chk("R5 bcast write far", 1'b0, 6'd5, 12'h004, 16'hBEEF);
      txn(1'b1, -1, OPW, 1'b0, 6'd3, 12'h004, 16'h1111);
      rd_chk("R5 bcast read from responder only", 1'b1, 6'd0, 12'h004, 16'hBEEF);
   endtask

   task automatic t_unimpl;
      txn(1'b1, -1, OPW, 1'b0, 6'd3, 12'h100, 16'h7777);
      rd_chk("R6 unimplemented reads zero", 1'b0, 6'd3, 12'h100, 16'h0000);
      txn(1'b1, -1, OPW, 1'b0, 6'd3, 12'h007, 16'h8001);
      rd_chk("R6 top implemented address", 1'b0, 6'd3, 12'h007, 16'h8001);
      txn(1'b1, -1, OPW, 1'b0, 6'd3, 12'h008, 16'h4242);
      rd_chk("R6 first unimplemented address", 1'b0, 6'd3, 12'h008, 16'h0000);
   endtask

   task automatic t_bad_frame;
      txn(1'b0, -1, OPW, 1'b0, 6'd3, 12'h002, 16'hDEAD);
      chk("R1 bad frame keeps repeating", r_fwd, 0);
      rd_chk("R1 bad frame no write", 1'b0, 6'd3, 12'h002, 16'hA5C3);
   endtask

   task automatic t_unknown_op;
      txn(1'b1, -1, 4'h7, 1'b0, 6'd3, 12'h002, 16'h5555);
      chk("R10 no response window", r_stray, 0);
      rd_chk("R10 no store", 1'b0, 6'd3, 12'h002, 16'hA5C3);
   endtask

   task automatic t_mid_frame;
      txn(1'b1, 20, OPW, 1'b0, 6'd3, 12'h003, 16'h0F0F);
      rd_chk("R11 pattern inside transaction ignored", 1'b0, 6'd3, 12'h003, 16'h0F0F);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_own_write();
      t_other_device();
      t_broadcast();
      t_unimpl();
      t_bad_frame();
      t_unknown_op();
      t_mid_frame();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule